// File: doc/BRIEF.md
# Aligned PWM Channel Generator

A single pulse-width modulated output channel. A clock-enable prescaler derives a channel tick from the master clock, either as a power-of-two fraction or through one of two programmable linear dividers. Each tick advances an internal ramp counter. In edge-aligned mode the counter only counts upward and wraps. In symmetric mode it climbs and then descends, which doubles the period for the same period setting and mirrors every pulse about the middle of the period. Two symmetric channels with suitable duty values therefore never overlap.

The output level comes from comparing the ramp counter with the active duty value. A polarity bit selects the level the output takes at the start of each period. Software may change the period, duty, polarity and alignment at any time. These values are held in active registers and reloaded only when a period ends, so a period in progress never mixes settings. When the channel is disabled, the output is low and the counter and prescaler are cleared. Enabling the channel starts a fresh period.

Top module: `pwm_aligned_chan`

## Requirements
- R1: In edge-aligned mode (`cfg_center`=0) the counter takes the values 0, 1, ..., P-1 on successive ticks and then returns to 0, so one period is P ticks. A period setting P of 0 behaves as 1.
- R2: In symmetric mode (`cfg_center`=1) the counter takes the values 0 .. P-1 and then P-1 .. 0, one value per tick, so one period is 2P ticks and the level pattern is mirrored about the middle of the period.
- R3: While the channel is enabled, `pwm_out` equals `cfg_pol` as latched for the period whenever the counter is below the duty value D, and the inverse of that level otherwise. A period with D>0 therefore starts at the polarity level.
- R4: Duty extremes give a constant output while enabled. D=0 gives the inverse of the polarity for the whole period. D>=P gives the polarity level (D=P with polarity 0 is constant 0; D=0 with polarity 0 is constant 1).
- R5: `cfg_clk_sel` values 0 to 10 give one tick every 2^sel master cycles. Value 11 uses divider A and value 12 uses divider B, each giving one tick every N cycles for a divider value N. Values 13 to 15 give no tick.
- R6: A divider value of 0 gives no tick, so the counter stays at 0 and the output holds the level for count 0.
- R7: Period, duty, polarity and alignment values presented while a period runs take effect only from the first cycle of the next period. A change presented in the last cycle of a period takes effect at that boundary.
- R8: `pwm_out` goes low one cycle after `enable` falls and stays low while disabled, whatever the settings. The prescaler and counter are cleared while disabled. The first cycle after `enable` is registered is count 0 of a new period that uses the settings present at that edge.
- R9: Reset drives `pwm_out` low and clears the counter, the prescaler and all active settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Channel run control, registered once |
| cfg_period | input | PW | Period setting P in ticks (one ramp) |
| cfg_duty | input | PW | Duty setting D compared with the counter |
| cfg_pol | input | 1 | Output level at the start of a period |
| cfg_center | input | 1 | 1 selects symmetric up/down counting |
| cfg_clk_sel | input | 4 | Tick source: 0..10 power of two, 11 divider A, 12 divider B |
| cfg_div_a | input | DW | Linear divider A value (0 = no tick) |
| cfg_div_b | input | DW | Linear divider B value (0 = no tick) |
| pwm_out | output | 1 | Waveform output |

## Verification
The hardest situation to reach from the ports is a settings change that lands exactly in the last cycle of a running period. The new values must wait for that boundary and then apply from the next cycle, with the prescaler phase kept. The bench computes the boundary cycle from the old settings and the tick divisor. It then presents new settings at random cycles inside the period and also in that final cycle, and compares every cycle against a closed-form waveform formula. Long prescaler ratios and duty values beyond the period are mixed into constrained random runs next to directed extreme cases.

// File: rtl/pwm_chan_pkg.sv
package pwm_chan_pkg;
  localparam int unsigned SEL_W     = 4;
  localparam int unsigned POW_STEPS = 11;
  localparam int unsigned PRE_W     = POW_STEPS - 1;
  localparam logic [SEL_W-1:0] SEL_POW_MAX = SEL_W'(POW_STEPS - 1);
  localparam logic [SEL_W-1:0] SEL_LIN_A   = SEL_W'(POW_STEPS);
  localparam logic [SEL_W-1:0] SEL_LIN_B   = SEL_W'(POW_STEPS + 1);
  localparam int unsigned LIN_COUNT = 2;

  // true on the last master cycle of each 2^k window
  function automatic logic pow2_hit(input logic [PRE_W-1:0] c, input logic [SEL_W-1:0] k);
    logic [PRE_W-1:0] mask;
    mask = (PRE_W'(1) << k) - PRE_W'(1);
    return (c & mask) == mask;
  endfunction
endpackage

// File: rtl/pwm_lin_div.sv
module pwm_lin_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [DW-1:0] div,
  output logic          pulse
);
  logic [DW-1:0] c_q;

  assign pulse = run && (div != '0) && (c_q == div - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) c_q <= '0;
    else if (!run || (div == '0) || pulse) c_q <= '0;
    else c_q <= c_q + 1'b1;
  end
endmodule

// File: rtl/pwm_prescale.sv
module pwm_prescale import pwm_chan_pkg::*; #(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  input  logic [DW-1:0]    div_a,
  input  logic [DW-1:0]    div_b,
  output logic             tick
);
  logic [PRE_W-1:0] pre_q;
  logic [LIN_COUNT-1:0][DW-1:0] divs;
  logic [LIN_COUNT-1:0] lin_pulse;

  assign divs = {div_b, div_a};

  always_ff @(posedge clk) begin
    if (!rst_n || !run) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  for (genvar g = 0; g < LIN_COUNT; g++) begin : g_lin
    pwm_lin_div #(.DW(DW)) u_div (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (divs[g]),
      .pulse(lin_pulse[g])
    );
  end

  always_comb begin
    if (sel <= SEL_POW_MAX) tick = run && pow2_hit(pre_q, sel);
    else if (sel == SEL_LIN_A) tick = lin_pulse[0];
    else if (sel == SEL_LIN_B) tick = lin_pulse[1];
    else tick = 1'b0;
  end
endmodule

// File: rtl/pwm_ramp.sv
module pwm_ramp #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          tick,
  input  logic [PW-1:0] cfg_period,
  input  logic [PW-1:0] cfg_duty,
  input  logic          cfg_pol,
  input  logic          cfg_center,
  output logic [PW-1:0] cnt_q,
  output logic          dir_down_q,
  output logic          period_end,
  output logic [PW-1:0] act_period,
  output logic [PW-1:0] act_duty,
  output logic          act_pol,
  output logic          act_center
);
  function automatic logic [PW-1:0] last_idx(input logic [PW-1:0] p);
    return (p == '0) ? '0 : p - 1'b1;
  endfunction

  logic [PW-1:0] top_val;
  logic          at_top;

  assign top_val    = last_idx(act_period);
  assign at_top     = cnt_q >= top_val;
  assign period_end = tick && (act_center ? (dir_down_q && (cnt_q == '0)) : at_top);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      dir_down_q <= 1'b0;
      act_period <= '0;
      act_duty   <= '0;
      act_pol    <= 1'b0;
      act_center <= 1'b0;
    end else if (!run || period_end) begin
      cnt_q      <= '0;
      dir_down_q <= 1'b0;
      act_period <= cfg_period;
      act_duty   <= cfg_duty;
      act_pol    <= cfg_pol;
      act_center <= cfg_center;
    end else if (tick) begin
      if (!act_center) cnt_q <= cnt_q + 1'b1;
      else if (!dir_down_q) begin
        if (at_top) dir_down_q <= 1'b1;
        else cnt_q <= cnt_q + 1'b1;
      end else cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/pwm_aligned_chan.sv
module pwm_aligned_chan import pwm_chan_pkg::*; #(
  parameter int PW = 16,
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [PW-1:0]    cfg_period,
  input  logic [PW-1:0]    cfg_duty,
  input  logic             cfg_pol,
  input  logic             cfg_center,
  input  logic [SEL_W-1:0] cfg_clk_sel,
  input  logic [DW-1:0]    cfg_div_a,
  input  logic [DW-1:0]    cfg_div_b,
  output logic             pwm_out
);
  function automatic logic level_at(input logic [PW-1:0] c, input logic [PW-1:0] d,
                                    input logic pol);
    return (c < d) ? pol : !pol;
  endfunction

  logic          en_q;
  logic          tick;
  logic          period_end;
  logic          dir_down_q;
  logic [PW-1:0] cnt_q;
  logic [PW-1:0] act_period;
  logic [PW-1:0] act_duty;
  logic          act_pol;
  logic          act_center;

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= 1'b0;
    else en_q <= enable;
  end

  pwm_prescale #(.DW(DW)) u_pre (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (en_q),
    .sel  (cfg_clk_sel),
    .div_a(cfg_div_a),
    .div_b(cfg_div_b),
    .tick (tick)
  );

  pwm_ramp #(.PW(PW)) u_ramp (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (en_q),
    .tick      (tick),
    .cfg_period(cfg_period),
    .cfg_duty  (cfg_duty),
    .cfg_pol   (cfg_pol),
    .cfg_center(cfg_center),
    .cnt_q     (cnt_q),
    .dir_down_q(dir_down_q),
    .period_end(period_end),
    .act_period(act_period),
    .act_duty  (act_duty),
    .act_pol   (act_pol),
    .act_center(act_center)
  );

  assign pwm_out = en_q && level_at(cnt_q, act_duty, act_pol);
endmodule

// File: rtl/pwm_chan_checker.sv
module pwm_chan_checker #(
  parameter int PW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          en_q,
  input logic          tick,
  input logic          period_end,
  input logic [PW-1:0] cnt,
  input logic          dir_down,
  input logic [PW-1:0] act_period,
  input logic [PW-1:0] act_duty,
  input logic          act_pol,
  input logic          act_center,
  input logic          pwm_out
);
  logic [PW-1:0] top_chk;
  assign top_chk = (act_period == '0) ? '0 : act_period - 1'b1;

  assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !pwm_out);

  assert_no_tick_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !tick);

  assert_cnt_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |-> cnt <= top_chk);

  assert_restart_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    period_end |=> cnt == '0);

  assert_left_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && tick && !period_end && !act_center |=> cnt == PW'($past(cnt) + 1'b1));

  assert_center_turn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && tick && act_center && !dir_down && (cnt >= top_chk) |=>
      dir_down && cnt == $past(cnt));

  assert_hold_cfg_R7: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && !period_end |=> $stable(act_period) && $stable(act_duty) &&
      $stable(act_pol) && $stable(act_center));

  assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
    en_q && (act_period != '0) && (act_duty >= act_period) |-> pwm_out == act_pol);
endmodule

bind pwm_aligned_chan pwm_chan_checker #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .enable    (enable),
  .en_q      (en_q),
  .tick      (tick),
  .period_end(period_end),
  .cnt       (cnt_q),
  .dir_down  (dir_down_q),
  .act_period(act_period),
  .act_duty  (act_duty),
  .act_pol   (act_pol),
  .act_center(act_center),
  .pwm_out   (pwm_out)
);

// File: tb/pwm_aligned_chan_bench.sv
`timescale 1ns/1ps
module pwm_aligned_chan_bench;
  localparam int PW = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [PW-1:0] cfg_period = '0;
  logic [PW-1:0] cfg_duty = '0;
  logic cfg_pol = 1'b0;
  logic cfg_center = 1'b0;
  logic [3:0] cfg_clk_sel = '0;
  logic [DW-1:0] cfg_div_a = '0;
  logic [DW-1:0] cfg_div_b = '0;
  logic pwm_out;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pwm_aligned_chan #(.PW(PW), .DW(DW)) u_pwm_aligned_chan (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_period(cfg_period), .cfg_duty(cfg_duty), .cfg_pol(cfg_pol),
    .cfg_center(cfg_center), .cfg_clk_sel(cfg_clk_sel),
    .cfg_div_a(cfg_div_a), .cfg_div_b(cfg_div_b), .pwm_out(pwm_out)
  );

  // master cycles per tick; 0 means no tick at all
  function automatic int tick_div(int sel, int da, int db);
    if (sel <= 10) return 1 << sel;
    if (sel == 11) return da;
    if (sel == 12) return db;
    return 0;
  endfunction

  function automatic int cycle_len(int n, int p, bit ctr);
    int pe;
    pe = (p == 0) ? 1 : p;
    return n * pe * (ctr ? 2 : 1);
  endfunction

  // closed form: level t master cycles after the period starts
  function automatic logic exp_level(int t, int n, int p, int d, bit pol, bit ctr);
    int pe, k, c;
    pe = (p == 0) ? 1 : p;
    k = (n == 0) ? 0 : t / n;
    if (ctr) begin
      k = k % (2 * pe);
      c = (k < pe) ? k : (2 * pe - 1 - k);
    end else c = k % pe;
    return (c < d) ? pol : !pol;
  endfunction

  task automatic check(input bit ok, input string tag, input int t,
                       input logic got, input logic exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s at t=%0d: got %b expected %b", tag, t, got, exp);
    end
  endtask

  task automatic set_cfg(int p, int d, bit pol, bit ctr);
    cfg_period = PW'(p);
    cfg_duty = PW'(d);
    cfg_pol = pol;
    cfg_center = ctr;
  endtask

  // leaves the bench at the negedge of cycle t=0 of a new period
  task automatic start(int p, int d, bit pol, bit ctr, int sel, int da, int db);
    enable = 1'b0;
    repeat (2) @(negedge clk);
    set_cfg(p, d, pol, ctr);
    cfg_clk_sel = 4'(sel);
    cfg_div_a = DW'(da);
    cfg_div_b = DW'(db);
    enable = 1'b1;
    @(negedge clk);
  endtask

  task automatic wave_check(input string tag, int p, int d, bit pol, bit ctr,
                            int sel, int da, int db, int len);
    int bad_t;
    logic got_b, exp_b;
    bad_t = -1;
    got_b = 1'b0;
    exp_b = 1'b0;
    start(p, d, pol, ctr, sel, da, db);
    for (int t = 0; t < len; t++) begin
      logic e;
      e = exp_level(t, tick_div(sel, da, db), p, d, pol, ctr);
      if (pwm_out !== e && bad_t < 0) begin
        bad_t = t; got_b = pwm_out; exp_b = e;
      end
      @(negedge clk);
    end
    check(bad_t < 0, tag, bad_t, got_b, exp_b);
  endtask

  // R7: new settings presented at cycle chg of the first period
  task automatic update_check(int p1, int d1, bit pol1, bit c1,
                              int p2, int d2, bit pol2, bit c2,
                              int sel, int da, int chg);
    int n, t1, len, bad_t;
    logic got_b, exp_b;
    n = tick_div(sel, da, da);
    t1 = cycle_len(n, p1, c1);
    len = t1 + 2 * cycle_len(n, p2, c2);
    bad_t = -1;
    got_b = 1'b0;
    exp_b = 1'b0;
    start(p1, d1, pol1, c1, sel, da, da);
    for (int t = 0; t < len; t++) begin
      logic e;
      if (t < t1) e = exp_level(t, n, p1, d1, pol1, c1);
      else e = exp_level(t - t1, n, p2, d2, pol2, c2);
      if (pwm_out !== e && bad_t < 0) begin
        bad_t = t; got_b = pwm_out; exp_b = e;
      end
      if (t == chg) set_cfg(p2, d2, pol2, c2);
      @(negedge clk);
    end
    check(bad_t < 0, "R7 boundary update", bad_t, got_b, exp_b);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b0, "R9 reset low", 0, pwm_out, 1'b0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(pwm_out == 1'b0, "R9 idle after reset", 0, pwm_out, 1'b0);

    // directed duty extremes (R4) and basic shapes (R1, R2, R3)
    wave_check("R4 d=p pol0 const0", 5, 5, 1'b0, 1'b0, 1, 0, 0, 30);
    wave_check("R4 d=0 pol0 const1", 5, 0, 1'b0, 1'b1, 0, 0, 0, 30);
    wave_check("R4 d=0 pol1 const0", 4, 0, 1'b1, 1'b0, 2, 0, 0, 40);
    wave_check("R4 d>p pol1 const1", 4, 9, 1'b1, 1'b1, 0, 0, 0, 30);
    wave_check("R1 left basic", 6, 2, 1'b1, 1'b0, 0, 0, 0, 24);
    wave_check("R2 center basic", 5, 2, 1'b0, 1'b1, 0, 0, 0, 40);
    wave_check("R3 pol start level", 7, 3, 1'b1, 1'b1, 1, 0, 0, 60);
    wave_check("R1 zero period as one", 0, 1, 1'b0, 1'b0, 0, 0, 0, 10);
    wave_check("R5 prescale 1024", 2, 1, 1'b1, 1'b0, 10, 0, 0, 2 * 2048 + 4);
    wave_check("R5 divider A", 3, 1, 1'b0, 1'b1, 11, 3, 7, 80);
    wave_check("R5 divider B", 3, 2, 1'b1, 1'b0, 12, 3, 7, 80);
    wave_check("R5 select 13 no tick", 3, 1, 1'b1, 1'b0, 13, 1, 1, 50);
    wave_check("R6 divider zero", 3, 1, 1'b0, 1'b0, 11, 0, 2, 50);

    // constrained random waveforms
    for (int i = 0; i < 30; i++) begin
      int p, d, sel, pick, da, db, n;
      bit pol, ctr;
      p = 1 + int'($urandom % 12);
      d = int'($urandom % (p + 3));
      pol = 1'($urandom % 2);
      ctr = 1'($urandom % 2);
      pick = int'($urandom % 6);
      sel = (pick < 4) ? pick : pick + 7;
      da = 1 + int'($urandom % 5);
      db = 1 + int'($urandom % 5);
      n = tick_div(sel, da, db);
      wave_check("R3 random wave", p, d, pol, ctr, sel, da, db, 2 * cycle_len(n, p, ctr) + 3);
    end

    // buffered updates, including the last cycle of a period
    update_check(4, 1, 1'b0, 1'b0, 6, 4, 1'b1, 1'b1, 1, 0, 2 * 4 - 1);
    update_check(3, 2, 1'b1, 1'b1, 5, 1, 1'b0, 1'b0, 11, 3, 3 * 6 - 1);
    update_check(5, 3, 1'b1, 1'b1, 2, 1, 1'b1, 1'b0, 0, 0, 0);
    for (int i = 0; i < 6; i++) begin
      int p1, p2, sel, t1;
      bit c1;
      p1 = 2 + int'($urandom % 6);
      p2 = 1 + int'($urandom % 6);
      c1 = 1'($urandom % 2);
      sel = int'($urandom % 3);
      t1 = cycle_len(1 << sel, p1, c1);
      update_check(p1, int'($urandom % (p1 + 1)), 1'($urandom % 2), c1,
                   p2, int'($urandom % (p2 + 1)), 1'($urandom % 2), 1'($urandom % 2),
                   sel, 0, int'($urandom % t1));
    end

    // disable drives low and ignores settings (R8)
    start(5, 0, 1'b0, 1'b0, 0, 0, 0);
    repeat (3) @(negedge clk);
    check(pwm_out == 1'b1, "R4 constant high before disable", 3, pwm_out, 1'b1);
    enable = 1'b0;
    @(negedge clk);
    check(pwm_out == 1'b0, "R8 low one cycle after disable", 0, pwm_out, 1'b0);
    begin
      bit seen_hi;
      seen_hi = 1'b0;
      for (int t = 0; t < 12; t++) begin
        set_cfg(t % 4, 0, 1'(t % 2), 1'(t % 3 == 0));
        @(negedge clk);
        if (pwm_out !== 1'b0) seen_hi = 1'b1;
      end
      check(!seen_hi, "R8 stays low while disabled", 12, seen_hi, 1'b0);
    end
    wave_check("R8 restart from count 0", 4, 2, 1'b1, 1'b1, 1, 0, 0, 40);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule